// File: doc/BRIEF.md
# Narrow-Wire Pin Command and Readback Link

This block carries set-up traffic between a group of processing cores and one pin-side peripheral over very few wires. Each core owns a command sender that drives a 3-bit lane, and the lanes of all cores are merged with a bitwise OR before they reach the pin. A core that is not sending must therefore drive zero. At the pin, a receiver watches the merged lane on every clock. A nonzero symbol opens a command, and the opcode fixes how many 3-bit payload symbols follow. Once the last symbol arrives, the receiver loads the mode register, the configuration register or one of the two data registers.

Results come back on a 4-bit return path without any handshake. The peripheral presents a 64-bit result word. The pin drives the nibble selected by a shared free-running system counter. The counter's three low bits pick the nibble and bit 3 picks the 32-bit half. A core-side gatherer waits until the counter reaches nibble 0 of the requested half. It then collects eight nibbles and reports the assembled word with a one-cycle valid pulse.

Sender states: `S_IDLE` and `S_SEND`. The transition *accept* (IDLE→SEND) happens on a go request with a nonzero opcode, and *drain* (SEND→IDLE) happens after the last payload symbol. Receiver states: `R_IDLE` and `R_PAYLOAD`. The transition *open* (IDLE→PAYLOAD) happens on any nonzero lane symbol, and *commit* (PAYLOAD→IDLE) happens on the final payload symbol. Gatherer states: `G_IDLE`, `G_ALIGN` and `G_COLLECT`. The transitions are *arm* (IDLE→ALIGN) on a read request, *lock* (ALIGN→COLLECT) when the counter's low bits are 0 and bit 3 equals the requested half, and *finish* (COLLECT→IDLE) on nibble 7.

Top module: `pcl_link`

## Requirements
- R1: An idle sender drives 000 on its lane. A go request whose opcode is 000 is not accepted, and the lane stays 000.
- R2: An accepted command appears on the lane in the clock after go. It starts with the opcode, followed by its payload symbols from least significant to most significant (symbol i carries argument bits 3i+2:3i). The sender's busy output is high while the opcode and each payload symbol are on the lane. A go request that arrives while busy is ignored.
- R3: The pin lane is the bitwise OR of every core's lane.
- R4: Opcode 001 loads the 6-bit mode from 2 payload symbols. Opcode 010 loads the 13-bit configuration from 5 symbols. Opcode 011 loads data register A and opcode 100 loads data register B, each from 11 symbols. Opcodes 101, 110 and 111 take exactly one payload symbol and change no register.
- R5: While a command's payload is being received, nonzero symbols are taken as payload and never open a new command. The target register changes in the clock edge that samples the last payload symbol, and at no other time.
- R6: Payload bits above the target register's width are discarded: the top 2 of the 15 configuration bits and the top bit of the 33 data bits.
- R7: The return nibble equals bits 4n+3:4n of the 64-bit result word, where n is the 4-bit system counter value. Bit 3 of the counter selects the upper half.
- R8: After a read request, the gatherer ignores further requests until it finishes. It collects nibbles 0 to 7 of the requested half on the counter values where the low bits run from 0 to 7. In the clock after nibble 7 it raises valid for exactly one cycle, and the word output holds the assembled value.
- R9: After reset, every register, lane and busy flag is zero and valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_cnt | input | 4 | Low bits of the shared free-running system counter |
| snd_go | input | 2 | Per-core command request |
| snd_op | input | 6 | Per-core 3-bit opcode, core c at bits 3c+2:3c |
| snd_arg | input | 64 | Per-core 32-bit argument, core c at bits 32c+31:32c |
| snd_busy | output | 2 | Per-core sender busy |
| pin_lane | output | 3 | OR-merged command lane seen by the pin |
| mode_q | output | 6 | Pin mode register |
| cfg_q | output | 13 | Pin configuration register |
| data_a_q | output | 32 | Pin data register A |
| data_b_q | output | 32 | Pin data register B |
| res_word | input | 64 | Result word offered by the peripheral |
| ret_nib | output | 4 | Return nibble on the 4-wire path |
| rd_go | input | 1 | Core read request |
| rd_half | input | 1 | Requested 32-bit half (1 selects the upper half) |
| rd_busy | output | 1 | Gatherer busy |
| rd_valid | output | 1 | One-cycle pulse when the read word is ready |
| rd_word | output | 32 | Gathered word |

## Verification
The properties assume three things about the inputs. The system counter advances by exactly one every clock. The result word stays steady while a read is collecting. Only cores that intend to share a command start sending in the same cycle. The stimulus meets these conditions because the bench owns the counter and increments it once per cycle, changes the result word only between reads, and starts overlapping commands from two cores only in scenarios where the OR-merged result is itself the expected value. A behavioural model built on symbol queues and integer counters predicts every output on every clock. Deliberate collisions, ignored requests and reserved opcodes are therefore checked against the same predictions as ordinary traffic.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

    localparam int unsigned SYM_W = 3;
    localparam int unsigned NIB_W = 4;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_MODE   = 3'd1,
        OP_CFG    = 3'd2,
        OP_DATA_A = 3'd3,
        OP_DATA_B = 3'd4,
        OP_RSV_5  = 3'd5,
        OP_RSV_6  = 3'd6,
        OP_RSV_7  = 3'd7
    } op_e;

    typedef enum logic {S_IDLE, S_SEND} snd_st_e;
    typedef enum logic {R_IDLE, R_PAYLOAD} rx_st_e;
    typedef enum logic [1:0] {G_IDLE, G_ALIGN, G_COLLECT} gt_st_e;

    function automatic int unsigned syms_for(input int unsigned bits);
        return (bits + SYM_W - 1) / SYM_W;
    endfunction

    // payload symbols that follow each opcode
    function automatic int unsigned pay_len(input op_e op, input int unsigned mw,
                                            input int unsigned cw, input int unsigned dw);
        case (op)
            OP_NONE:              return 0;
            OP_MODE:              return syms_for(mw);
            OP_CFG:               return syms_for(cw);
            OP_DATA_A, OP_DATA_B: return syms_for(dw);
            default:              return 1;
        endcase
    endfunction

endpackage

// File: rtl/pcl_sender.sv
module pcl_sender
    import pcl_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned MODE_W = 6,
    parameter int unsigned CFG_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [SYM_W-1:0]  op,
    input  logic [DATA_W-1:0] arg,
    output logic [SYM_W-1:0]  lane,
    output logic              busy
);
    localparam int unsigned NSYM  = syms_for(DATA_W);
    localparam int unsigned SH_W  = NSYM * SYM_W;
    localparam int unsigned CNT_W = $clog2(NSYM + 1);

    snd_st_e            state, state_nxt;
    logic [SYM_W-1:0]   lane_q;
    logic [SH_W-1:0]    sh_q;
    logic [CNT_W-1:0]   rem_q;
    logic               accept;

    assign accept = (state == S_IDLE) && go && (op != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: if (accept)        state_nxt = S_SEND;
            S_SEND: if (rem_q == '0)   state_nxt = S_IDLE;
            default:                   state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
            sh_q   <= '0;
            rem_q  <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (accept) begin
                        lane_q <= op;
                        sh_q   <= SH_W'(arg);
                        rem_q  <= CNT_W'(pay_len(op_e'(op), MODE_W, CFG_W, DATA_W));
                    end else begin
                        lane_q <= '0;
                    end
                end
                S_SEND: begin
                    if (rem_q != '0) begin
                        lane_q <= sh_q[SYM_W-1:0];
                        sh_q   <= sh_q >> SYM_W;
                        rem_q  <= rem_q - 1'b1;
                    end else begin
                        lane_q <= '0;
                    end
                end
                default: lane_q <= '0;
            endcase
        end
    end

    assign lane = lane_q;
    assign busy = (state == S_SEND);

endmodule

// File: rtl/pcl_receiver.sv
module pcl_receiver
    import pcl_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned MODE_W = 6,
    parameter int unsigned CFG_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SYM_W-1:0]  lane,
    output logic [MODE_W-1:0] mode_q,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [DATA_W-1:0] data_a_q,
    output logic [DATA_W-1:0] data_b_q,
    output logic              busy
);
    localparam int unsigned NSYM  = syms_for(DATA_W);
    localparam int unsigned ACC_W = NSYM * SYM_W;
    localparam int unsigned CNT_W = $clog2(NSYM + 1);

    rx_st_e             state, state_nxt;
    op_e                op_q;
    logic [CNT_W-1:0]   rem_q;
    logic [CNT_W-1:0]   idx_q;
    logic [ACC_W-1:0]   acc_q, acc_nxt;
    logic               last_sym;
    logic               unused_hi;

    assign last_sym = (rem_q == CNT_W'(1));

    always_comb begin
        acc_nxt = acc_q;
        acc_nxt[int'(idx_q) * SYM_W +: SYM_W] = lane;
    end

    assign unused_hi = ^acc_nxt[ACC_W-1:DATA_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= R_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            R_IDLE:    if (lane != '0) state_nxt = R_PAYLOAD;
            R_PAYLOAD: if (last_sym)   state_nxt = R_IDLE;
            default:                   state_nxt = R_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_NONE;
            rem_q    <= '0;
            idx_q    <= '0;
            acc_q    <= '0;
            mode_q   <= '0;
            cfg_q    <= '0;
            data_a_q <= '0;
            data_b_q <= '0;
        end else begin
            unique case (state)
                R_IDLE: begin
                    if (lane != '0) begin
                        op_q  <= op_e'(lane);
                        rem_q <= CNT_W'(pay_len(op_e'(lane), MODE_W, CFG_W, DATA_W));
                        idx_q <= '0;
                        acc_q <= '0;
                    end
                end
                R_PAYLOAD: begin
                    acc_q <= acc_nxt;
                    idx_q <= idx_q + 1'b1;
                    rem_q <= rem_q - 1'b1;
                    if (last_sym) begin
                        case (op_q)
                            OP_MODE:   mode_q   <= acc_nxt[MODE_W-1:0];
                            OP_CFG:    cfg_q    <= acc_nxt[CFG_W-1:0];
                            OP_DATA_A: data_a_q <= acc_nxt[DATA_W-1:0];
                            OP_DATA_B: data_b_q <= acc_nxt[DATA_W-1:0];
                            default: ;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy = (state == R_PAYLOAD);

endmodule

// File: rtl/pcl_gather.sv
module pcl_gather
    import pcl_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [$clog2(WORD_W/NIB_W):0]     cnt,
    input  logic [NIB_W-1:0]                  nib,
    input  logic                              go,
    input  logic                              half,
    output logic                              busy,
    output logic                              valid,
    output logic [WORD_W-1:0]                 word
);
    localparam int unsigned NNIB = WORD_W / NIB_W;
    localparam int unsigned PH_W = $clog2(NNIB);

    gt_st_e             state, state_nxt;
    logic               half_q;
    logic [WORD_W-1:0]  sh_q, word_q;
    logic               valid_q;
    logic [PH_W-1:0]    phase;
    logic               aligned, last;

    assign phase   = cnt[PH_W-1:0];
    assign aligned = (phase == '0) && (cnt[PH_W] == half_q);
    assign last    = (phase == PH_W'(NNIB - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= G_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            G_IDLE:    if (go)      state_nxt = G_ALIGN;
            G_ALIGN:   if (aligned) state_nxt = G_COLLECT;
            G_COLLECT: if (last)    state_nxt = G_IDLE;
            default:                state_nxt = G_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q  <= 1'b0;
            sh_q    <= '0;
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (state)
                G_IDLE:    if (go) half_q <= half;
                G_ALIGN:   if (aligned) sh_q <= {nib, sh_q[WORD_W-1:NIB_W]};
                G_COLLECT: begin
                    sh_q <= {nib, sh_q[WORD_W-1:NIB_W]};
                    if (last) begin
                        word_q  <= {nib, sh_q[WORD_W-1:NIB_W]};
                        valid_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy  = (state != G_IDLE);
    assign valid = valid_q;
    assign word  = word_q;

endmodule

// File: rtl/pcl_link.sv
module pcl_link
    import pcl_pkg::*;
#(
    parameter int unsigned NUM_CORES = 2,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned MODE_W    = 6,
    parameter int unsigned CFG_W     = 13
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [$clog2(DATA_W/NIB_W):0]    sys_cnt,
    input  logic [NUM_CORES-1:0]             snd_go,
    input  logic [NUM_CORES*SYM_W-1:0]       snd_op,
    input  logic [NUM_CORES*DATA_W-1:0]      snd_arg,
    output logic [NUM_CORES-1:0]             snd_busy,
    output logic [SYM_W-1:0]                 pin_lane,
    output logic [MODE_W-1:0]                mode_q,
    output logic [CFG_W-1:0]                 cfg_q,
    output logic [DATA_W-1:0]                data_a_q,
    output logic [DATA_W-1:0]                data_b_q,
    input  logic [2*DATA_W-1:0]              res_word,
    output logic [NIB_W-1:0]                 ret_nib,
    input  logic                             rd_go,
    input  logic                             rd_half,
    output logic                             rd_busy,
    output logic                             rd_valid,
    output logic [DATA_W-1:0]                rd_word
);
    logic [SYM_W-1:0] core_lane [NUM_CORES];
    logic             rx_busy;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        pcl_sender #(.DATA_W(DATA_W), .MODE_W(MODE_W), .CFG_W(CFG_W)) u_snd (
            .clk  (clk),
            .rst_n(rst_n),
            .go   (snd_go[c]),
            .op   (snd_op[c*SYM_W +: SYM_W]),
            .arg  (snd_arg[c*DATA_W +: DATA_W]),
            .lane (core_lane[c]),
            .busy (snd_busy[c])
        );
    end

    always_comb begin
        pin_lane = '0;
        for (int c = 0; c < NUM_CORES; c++) pin_lane = pin_lane | core_lane[c];
    end

    pcl_receiver #(.DATA_W(DATA_W), .MODE_W(MODE_W), .CFG_W(CFG_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane    (pin_lane),
        .mode_q  (mode_q),
        .cfg_q   (cfg_q),
        .data_a_q(data_a_q),
        .data_b_q(data_b_q),
        .busy    (rx_busy)
    );

    assign ret_nib = res_word[int'(sys_cnt) * NIB_W +: NIB_W];

    pcl_gather #(.WORD_W(DATA_W)) u_gt (
        .clk  (clk),
        .rst_n(rst_n),
        .cnt  (sys_cnt),
        .nib  (ret_nib),
        .go   (rd_go),
        .half (rd_half),
        .busy (rd_busy),
        .valid(rd_valid),
        .word (rd_word)
    );

endmodule

// File: rtl/pcl_link_chk.sv
module pcl_link_chk #(
    parameter int unsigned NUM_CORES = 2,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned MODE_W    = 6,
    parameter int unsigned CNT_W     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           pin_lane,
    input logic [NUM_CORES-1:0] snd_busy,
    input logic                 rx_busy,
    input logic [MODE_W-1:0]    mode_q,
    input logic [DATA_W-1:0]    data_a_q,
    input logic                 rd_valid,
    input logic                 rd_busy,
    input logic [CNT_W-1:0]     sys_cnt
);
    p_idle_lane_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_busy == '0) |-> (pin_lane == '0));

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_start
        p_code_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(snd_busy[c]) |-> (pin_lane != '0));
    end

    p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> $past(rx_busy));

    p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_a_q) |-> $past(rx_busy));

    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_valid_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (&$past(sys_cnt[CNT_W-2:0])));

    p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_busy) |-> rd_valid);

endmodule

bind pcl_link pcl_link_chk #(
    .NUM_CORES(NUM_CORES), .DATA_W(DATA_W), .MODE_W(MODE_W),
    .CNT_W($clog2(DATA_W/pcl_pkg::NIB_W) + 1)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_lane(pin_lane),
    .snd_busy(snd_busy),
    .rx_busy (rx_busy),
    .mode_q  (mode_q),
    .data_a_q(data_a_q),
    .rd_valid(rd_valid),
    .rd_busy (rd_busy),
    .sys_cnt (sys_cnt)
);

// File: tb/tb_pcl_link.sv
module tb_pcl_link;
    localparam int NC = 2;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n = 1'b0;
    logic [3:0]      sys_cnt = '0;
    logic [NC-1:0]   snd_go = '0;
    logic [3*NC-1:0] snd_op = '0;
    logic [DW*NC-1:0] snd_arg = '0;
    logic [NC-1:0]   snd_busy;
    logic [2:0]      pin_lane;
    logic [5:0]      mode_q;
    logic [12:0]     cfg_q;
    logic [31:0]     data_a_q, data_b_q;
    logic [63:0]     res_word = '0;
    logic [3:0]      ret_nib;
    logic            rd_go = 1'b0, rd_half = 1'b0;
    logic            rd_busy, rd_valid;
    logic [31:0]     rd_word;

    pcl_link dut (
        .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt),
        .snd_go(snd_go), .snd_op(snd_op), .snd_arg(snd_arg), .snd_busy(snd_busy),
        .pin_lane(pin_lane), .mode_q(mode_q), .cfg_q(cfg_q),
        .data_a_q(data_a_q), .data_b_q(data_b_q),
        .res_word(res_word), .ret_nib(ret_nib),
        .rd_go(rd_go), .rd_half(rd_half), .rd_busy(rd_busy),
        .rd_valid(rd_valid), .rd_word(rd_word)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int sq0[$];
    int sq1[$];
    int rrem = 0, rop = 0, ridx = 0;
    longint racc = 0;
    logic [5:0]  m_mode = '0;
    logic [12:0] m_cfg = '0;
    logic [31:0] m_da = '0, m_db = '0;
    int gst = 0;
    logic ghalf = 1'b0;
    logic [31:0] gacc = '0, gword = '0;
    logic gval = 1'b0;

    function automatic int plen(input int op);
        case (op)
            1: return 2;
            2: return 5;
            3, 4: return 11;
            5, 6, 7: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_lane();
        int l0 = (sq0.size() > 0) ? sq0[0] : 0;
        int l1 = (sq1.size() > 0) ? sq1[0] : 0;
        return l0 | l1;
    endfunction

    task automatic model_step();
        int L = exp_lane();
        int nibv = int'(res_word[4*int'(sys_cnt) +: 4]);
        // pin receiver
        if (rrem == 0) begin
            if (L != 0) begin rop = L; rrem = plen(L); ridx = 0; racc = 0; end
        end else begin
            racc = racc | (longint'(L) << (3*ridx));
            ridx++;
            rrem--;
            if (rrem == 0) begin
                case (rop)
                    1: m_mode = racc[5:0];
                    2: m_cfg  = racc[12:0];
                    3: m_da   = racc[31:0];
                    4: m_db   = racc[31:0];
                    default: ;
                endcase
            end
        end
        // gatherer
        gval = 1'b0;
        case (gst)
            0: if (rd_go) begin gst = 1; ghalf = rd_half; end
            1: if (sys_cnt[2:0] == 3'd0 && sys_cnt[3] == ghalf) begin
                   gacc[3:0] = nibv[3:0]; gst = 2;
               end
            default: begin
                gacc[4*int'(sys_cnt[2:0]) +: 4] = nibv[3:0];
                if (sys_cnt[2:0] == 3'd7) begin gword = gacc; gval = 1'b1; gst = 0; end
            end
        endcase
        // senders
        for (int c = 0; c < NC; c++) begin
            int op = int'(snd_op[3*c +: 3]);
            longint a = longint'(snd_arg[DW*c +: DW]);
            int sz = (c == 0) ? sq0.size() : sq1.size();
            if (sz > 0) begin
                if (c == 0) void'(sq0.pop_front()); else void'(sq1.pop_front());
            end else if (snd_go[c] && op != 0) begin
                if (c == 0) sq0.push_back(op); else sq1.push_back(op);
                for (int i = 0; i < plen(op); i++) begin
                    int s = int'((a >> (3*i)) & 7);
                    if (c == 0) sq0.push_back(s); else sq1.push_back(s);
                end
            end
        end
    endtask

    task automatic compare();
        chk("R3", "pin_lane", 64'(pin_lane), 64'(exp_lane()));
        chk("R2", "snd_busy0", 64'(snd_busy[0]), 64'(sq0.size() > 0));
        chk("R2", "snd_busy1", 64'(snd_busy[1]), 64'(sq1.size() > 0));
        chk("R4", "mode_q", 64'(mode_q), 64'(m_mode));
        chk("R4", "cfg_q", 64'(cfg_q), 64'(m_cfg));
        chk("R4", "data_a_q", 64'(data_a_q), 64'(m_da));
        chk("R4", "data_b_q", 64'(data_b_q), 64'(m_db));
        chk("R7", "ret_nib", 64'(ret_nib), 64'(res_word[4*int'(sys_cnt) +: 4]));
        chk("R8", "rd_busy", 64'(rd_busy), 64'(gst != 0));
        chk("R8", "rd_valid", 64'(rd_valid), 64'(gval));
        chk("R8", "rd_word", 64'(rd_word), 64'(gword));
    endtask

    task automatic cyc();
        model_step();
        @(negedge clk);
        compare();
        sys_cnt = sys_cnt + 4'd1;
    endtask

    task automatic send(input int c, input int op, input logic [31:0] arg);
        snd_go[c] = 1'b1;
        snd_op[3*c +: 3] = 3'(op);
        snd_arg[DW*c +: DW] = arg;
        cyc();
        snd_go[c] = 1'b0;
    endtask

    task automatic drain();
        while (sq0.size() > 0 || sq1.size() > 0 || rrem != 0) cyc();
        cyc();
    endtask

    task automatic read(input logic half);
        rd_go = 1'b1; rd_half = half;
        cyc();
        rd_go = 1'b0;
        while (gst != 0) cyc();
        chk("R8", "read word", 64'(rd_word), half ? 64'(res_word[63:32]) : 64'(res_word[31:0]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "lane", 64'(pin_lane), 0);
        chk("R9", "busy", 64'({snd_busy, rd_busy, rd_valid}), 0);
        chk("R9", "regs", 64'(mode_q) | 64'(cfg_q) | 64'(data_a_q) | 64'(data_b_q), 0);
        rst_n = 1'b1;
        cyc();

        // R1: opcode 000 is not accepted
        send(0, 0, 32'hFFFF_FFFF);
        chk("R1", "lane after op 000", 64'(pin_lane), 0);
        chk("R1", "busy after op 000", 64'(snd_busy), 0);
        cyc();

        // R4: each register loaded
        send(0, 1, 32'h0000_002D);
        chk("R2", "opcode on lane", 64'(pin_lane), 1);
        drain();
        chk("R4", "mode loaded", 64'(mode_q), 64'h2D);
        // R6: excess config bits dropped
        send(1, 2, 32'hFFFF_FFFF);
        drain();
        chk("R6", "cfg truncated", 64'(cfg_q), 64'h1FFF);
        send(0, 3, 32'hDEAD_BEEF);
        drain();
        chk("R4", "data A", 64'(data_a_q), 64'hDEAD_BEEF);
        send(1, 4, 32'h1234_5678);
        drain();
        chk("R4", "data B", 64'(data_b_q), 64'h1234_5678);

        // R4: reserved opcodes change nothing
        send(0, 5, 32'h0000_0003);
        drain();
        send(1, 7, 32'h0000_0006);
        drain();
        chk("R4", "reserved kept mode", 64'(mode_q), 64'h2D);
        chk("R4", "reserved kept data B", 64'(data_b_q), 64'h1234_5678);

        // R5: payload of all-001 symbols does not open new commands
        send(0, 4, 32'h4924_9249);
        drain();
        chk("R5", "data B all-one symbols", 64'(data_b_q), 64'h4924_9249);
        chk("R5", "mode untouched", 64'(mode_q), 64'h2D);

        // R2: go while busy ignored
        send(0, 3, 32'h0BAD_F00D);
        cyc();
        send(0, 4, 32'hFFFF_0000);
        drain();
        chk("R2", "second go ignored", 64'(data_b_q), 64'h4924_9249);
        chk("R2", "first cmd landed", 64'(data_a_q), 64'h0BAD_F00D);

        // R3: two cores in the same cycle merge by OR
        snd_go = 2'b11;
        snd_op = {3'd1, 3'd1};
        snd_arg = {32'h0000_000A, 32'h0000_0005};
        cyc();
        snd_go = '0;
        drain();
        chk("R3", "merged mode", 64'(mode_q), 64'h0F);

        // staggered collision, tracked by the model
        send(0, 3, 32'h1111_1111);
        cyc(); cyc();
        send(1, 2, 32'h0000_0ABC);
        drain();

        // R7/R8: readback of both halves at various phases
        res_word = 64'hFEDC_BA98_7654_3210;
        read(1'b0);
        cyc(); cyc(); cyc();
        read(1'b1);
        res_word = 64'h0F1E_2D3C_4B5A_6978;
        cyc();
        rd_go = 1'b1; rd_half = 1'b1;
        cyc(); cyc();
        rd_half = 1'b0;
        cyc();
        rd_go = 1'b0;
        while (gst != 0) cyc();
        chk("R8", "request while busy ignored", 64'(rd_word), 64'h0F1E_2D3C);
        read(1'b0);
        repeat (4) cyc();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule